// File: doc/BRIEF.md
# Platform Interrupt Controller

This block gathers interrupt request lines from a parameterised set of sources and presents them to a few hart contexts. Every source ID other than 0 has a small programmable priority and its own gateway, which turns a level-high or rising-edge input into a single pending request. Each context keeps a per-source enable vector and a priority threshold. It raises its interrupt output while at least one enabled, pending source is ranked strictly above that threshold.

Software services a context in two steps. It reads the context's claim register, which returns the winning source ID and clears that source's pending bit in the same cycle. It then writes the ID back to the same register to finish. Between those two steps the source is held off: its gateway forwards no new request, so no context can see it pending. The register bus has separate read and write ports. A read returns its data on the cycle after the strobe. A claim read and a completion write can both occur in one cycle; the read is applied first.

Top module: `plic_top`

## Requirements
- R1: After reset every priority, enable and threshold register reads 0, every interrupt output is low, and a claim read returns 0.
- R2: The priority of source n is at byte address 4*n. Only the low 3 bits are stored and the upper bits read 0. The word for ID 0 reads 0 and ignores writes.
- R3: Context c's enable vector starts at 0x2000 + c*0x80. Source n is bit n mod 32 of word n div 32. The bit for ID 0 reads 0 whatever is written.
- R4: irq_o[c] is a registered output. It goes high only when some source is pending and enabled for c and has a priority strictly greater than c's threshold, so priority 0 never fires and threshold 7 silences the context. The threshold is at 0x200000 + c*0x1000.
- R5: A read of the claim register at 0x200004 + c*0x1000 returns the eligible source with the highest priority, and the lowest ID among sources of equal priority. It returns 0 when no source is eligible. rd_data_o holds the value from the cycle after rd_en_i.
- R6: A claim clears the winning source's pending bit. Pending bits can be read at 0x1000 + 4*w, with source n at bit n mod 32 of word w = n div 32.
- R7: A source that has been claimed and not yet completed is never pending, and no context can claim it, even while its input stays active.
- R8: Writing ID n to context c's claim register completes source n only if n is enabled in c at that moment. Otherwise the write is ignored and the source stays held.
- R9: A source whose bit in EDGE_MASK is 0 is level-high: it becomes pending while its input is high, and it pends again after completion if the input is still high.
- R10: A source whose bit in EDGE_MASK is 1 is rising-edge: only a 0-to-1 transition creates a request, so an input held high does not pend again after completion.
- R11: When a claim read and a completion write occur in the same cycle, the read picks its winner from the state before the completion, and the completion still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_IDS | Source request lines; bit 0 is ignored |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 22 | Read byte address |
| rd_data_o | output | 32 | Read data, valid the cycle after the strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 22 | Write byte address |
| wr_data_i | input | 32 | Write data |
| irq_o | output | N_CTX | Per-context interrupt request, registered |

## Verification
Arbitration is driven from a table of level-input patterns. Each row pairs a set of active sources with an enable mask and a threshold. The rows separate a single source from a strict priority winner, equal-priority ties, a priority-0 source, a threshold equal to the best priority (which must not fire), a silencing threshold of 7, and a masked-off winner. Directed sequences then probe the held window: a second context's claim during that window, a completion written while the source is disabled, level re-pend against an edge input held high, and a claim read in the same cycle as a completion.

// File: rtl/plic_pkg.sv
package plic_pkg;

  localparam int ADDR_W = 22;

  typedef enum logic [2:0] {
    K_NONE, K_PRIO, K_PEND, K_EN, K_THR, K_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [8:0]  ctx;
    logic [9:0]  idx;
  } reg_sel_t;

  // Strict comparison: equal to threshold is not enough.
  function automatic logic prio_wins(input logic [2:0] p, input logic [2:0] t);
    return p > t;
  endfunction

  // Address decode for the register map.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int n_ids, input int n_ctx);
    reg_sel_t s;
    int words;
    int off;
    words = (n_ids + 31) / 32;
    s = '{kind: K_NONE, ctx: '0, idx: '0};
    if (a[1:0] == 2'b00) begin
      if (a[21:12] == 10'd0) begin
        if (int'(a[11:2]) < n_ids) begin
          s.kind = K_PRIO;
          s.idx  = a[11:2];
        end
      end else if (a[21:12] == 10'd1) begin
        if (a[11:7] == 5'd0 && int'(a[6:2]) < words) begin
          s.kind = K_PEND;
          s.idx  = {5'd0, a[6:2]};
        end
      end else if (a[21] == 1'b0) begin
        off = int'(a) - 32'h2000;
        if (off >= 0 && (off >> 7) < n_ctx && ((off >> 2) & 31) < words) begin
          s.kind = K_EN;
          s.ctx  = 9'(off >> 7);
          s.idx  = 10'((off >> 2) & 31);
        end
      end else begin
        if (int'(a[20:12]) < n_ctx && a[11:3] == 9'd0) begin
          s.kind = a[2] ? K_CLAIM : K_THR;
          s.ctx  = a[20:12];
        end
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic inflight_o
);
  logic pend_q, held_q, req;

  generate
    if (EDGE) begin : g_edge
      logic src_q;
      always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src_i;
      end
      assign req = src_i & ~src_q;
      assert_edge_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> ($past(src_i) && !$past(src_q)));
    end else begin : g_level
      assign req = src_i;
      assert_level_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(src_i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~claim_i) | (req & ~pend_q & ~held_q);
      held_q <= (held_q | claim_i) & ~complete_i;
    end
  end

  assign pending_o  = pend_q;
  assign inflight_o = held_q;

  assert_held_not_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && held_q));
  assert_claim_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> !pend_q);
  assert_release_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) |-> $past(complete_i));
endmodule

// File: rtl/plic_target.sv
module plic_target
  import plic_pkg::*;
#(
  parameter int NUM_IDS = 32,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_IDS-1:0]               pend_i,
  input  logic [NUM_IDS-1:0]               en_i,
  input  logic [NUM_IDS-1:0][PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W-1:0]                thr_i,
  output logic [ID_W-1:0]                  win_id_o,
  output logic                             win_any_o
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with strict compare keeps the lowest ID on ties.
  always_comb begin
    win_id_o  = '0;
    win_any_o = 1'b0;
    best      = thr_i;
    for (int i = 1; i < NUM_IDS; i++) begin
      if (pend_i[i] && en_i[i] && prio_wins(prio_i[i], best)) begin
        best      = prio_i[i];
        win_id_o  = ID_W'(i);
        win_any_o = 1'b1;
      end
    end
  end

  assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_any_o |-> (pend_i[win_id_o] && en_i[win_id_o] && prio_i[win_id_o] > thr_i));
  assert_winner_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_any_o |-> (win_id_o != '0));
endmodule

// File: rtl/plic_top.sv
module plic_top
  import plic_pkg::*;
#(
  parameter int                 NUM_IDS   = 32,
  parameter int                 N_CTX     = 2,
  parameter int                 PRIO_W    = 3,
  parameter logic [NUM_IDS-1:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IDS-1:0]   src_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [31:0]          rd_data_o,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [31:0]          wr_data_i,
  output logic [N_CTX-1:0]     irq_o
);
  localparam int ID_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
  localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1;
  localparam int WORDS = (NUM_IDS + 31) / 32;

  logic [NUM_IDS-1:0][PRIO_W-1:0] prio_q;
  logic [N_CTX-1:0][NUM_IDS-1:0]  en_q;
  logic [N_CTX-1:0][PRIO_W-1:0]   thr_q;
  logic [N_CTX-1:0][ID_W-1:0]     win_id;
  logic [N_CTX-1:0]               win_any;
  logic [N_CTX-1:0]               irq_q;
  logic [NUM_IDS-1:0]             pend, held, claim_src, cmp_src;
  logic [31:0]                    rd_val, rd_q;

  reg_sel_t rsel, wsel;
  logic [CTX_W-1:0] rctx, wctx;
  logic [ID_W-1:0]  ridx, widx;

  assign rsel = decode_addr(rd_addr_i, NUM_IDS, N_CTX);
  assign wsel = decode_addr(wr_addr_i, NUM_IDS, N_CTX);
  assign rctx = rsel.ctx[CTX_W-1:0];
  assign wctx = wsel.ctx[CTX_W-1:0];
  assign ridx = rsel.idx[ID_W-1:0];
  assign widx = wsel.idx[ID_W-1:0];

  // Named events: a claim read, and a completion write.
  logic claim_rd, cmp_wr;
  assign claim_rd = rd_en_i && rsel.kind == K_CLAIM;
  assign cmp_wr   = wr_en_i && wsel.kind == K_CLAIM;

  assign pend[0]      = 1'b0;
  assign held[0]      = 1'b0;
  assign claim_src[0] = 1'b0;
  assign cmp_src[0]   = 1'b0;

  generate
    for (genvar i = 1; i < NUM_IDS; i++) begin : g_src
      assign claim_src[i] = claim_rd && win_any[rctx] && win_id[rctx] == ID_W'(i);
      assign cmp_src[i]   = cmp_wr && wr_data_i == 32'(i) && en_q[wctx][i];
      plic_gateway #(.EDGE(EDGE_MASK[i])) u_gw (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i[i]),
        .claim_i    (claim_src[i]),
        .complete_i (cmp_src[i]),
        .pending_o  (pend[i]),
        .inflight_o (held[i])
      );
    end
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      plic_target #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .en_i      (en_q[c]),
        .prio_i    (prio_q),
        .thr_i     (thr_q[c]),
        .win_id_o  (win_id[c]),
        .win_any_o (win_any[c])
      );
      assert_claim_above_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && rctx == CTX_W'(c) && win_any[c]) |-> (prio_q[win_id[c]] > thr_q[c]));
    end
  endgenerate

  // Register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_en_i) begin
      case (wsel.kind)
        K_PRIO: if (widx != '0) prio_q[widx] <= wr_data_i[PRIO_W-1:0];
        K_EN: begin
          for (int b = 0; b < 32; b++) begin
            if (int'(wsel.idx) * 32 + b < NUM_IDS && int'(wsel.idx) * 32 + b != 0)
              en_q[wctx][int'(wsel.idx) * 32 + b] <= wr_data_i[b];
          end
        end
        K_THR: thr_q[wctx] <= wr_data_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    case (rsel.kind)
      K_PRIO:  rd_val[PRIO_W-1:0] = prio_q[ridx];
      K_PEND: begin
        for (int b = 0; b < 32; b++)
          if (int'(rsel.idx) * 32 + b < NUM_IDS) rd_val[b] = pend[int'(rsel.idx) * 32 + b];
      end
      K_EN: begin
        for (int b = 0; b < 32; b++)
          if (int'(rsel.idx) * 32 + b < NUM_IDS) rd_val[b] = en_q[rctx][int'(rsel.idx) * 32 + b];
      end
      K_THR:   rd_val[PRIO_W-1:0] = thr_q[rctx];
      K_CLAIM: rd_val[ID_W-1:0]   = win_id[rctx];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      irq_q <= '0;
    end else begin
      if (rd_en_i) rd_q <= rd_val;
      irq_q <= win_any;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

  assert_one_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(claim_src) <= 1);
  assert_id0_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prio_q[0] == '0 && en_q[0][0] == 1'b0);

  logic unused_ok;
  assign unused_ok = ^{WORDS, rsel.idx, wsel.idx};
endmodule

// File: tb/tb_plic_top.sv
module tb_plic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [21:0] rd_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  plic_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_o(irq)
  );

  localparam logic [21:0] PEND0 = 22'h001000;
  localparam logic [21:0] EN0   = 22'h002000;
  localparam logic [21:0] EN1   = 22'h002080;
  localparam logic [21:0] THR0  = 22'h200000;
  localparam logic [21:0] CLM0  = 22'h200004;
  localparam logic [21:0] THR1  = 22'h201000;
  localparam logic [21:0] CLM1  = 22'h201004;

  // Row: lines[22:15] (bit k = ID k+1), enable[14:7], threshold[6:4], expected claim[3:0]
  localparam int NROWS = 10;
  localparam logic [22:0] ROWS [NROWS] = '{
    {8'b0000_0001, 8'hFF,        3'd0, 4'd1},
    {8'b0000_0011, 8'hFF,        3'd0, 4'd2},
    {8'b0000_0110, 8'hFF,        3'd0, 4'd2},
    {8'b0000_1000, 8'hFF,        3'd0, 4'd0},
    {8'b0101_0000, 8'hFF,        3'd0, 4'd5},
    {8'b0000_0111, 8'hFF,        3'd5, 4'd0},
    {8'b0000_0011, 8'hFF,        3'd4, 4'd2},
    {8'b0001_0000, 8'hFF,        3'd7, 4'd0},
    {8'b0000_0110, 8'b1111_1101, 3'd0, 4'd3},
    {8'b1010_0000, 8'hFF,        3'd1, 4'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    logic [31:0] id;
    wr(EN0, 32'hFFFF_FFFF);
    wr(THR0, 32'd0);
    for (int k = 0; k < 40; k++) begin
      rd(CLM0, id);
      if (id == 0) break;
      wr(CLM0, id);
    end
    idle(2);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    check("R1 irq", {30'd0, irq}, 32'd0);
    rd(22'h000004, d); check("R1 prio", d, 0);
    rd(EN0, d);        check("R1 enable", d, 0);
    rd(THR1, d);       check("R1 threshold", d, 0);
    rd(CLM0, d);       check("R1 claim", d, 0);

    // R2: priority width and ID 0
    wr(22'h00000C, 32'hFFFF_FFFF);
    rd(22'h00000C, d); check("R2 prio upper bits", d, 7);
    wr(22'h000000, 32'd5);
    rd(22'h000000, d); check("R2 id0 prio", d, 0);

    // R3: enable layout, ID 0 bit
    wr(EN1, 32'hFFFF_FFFF);
    rd(EN1, d); check("R3 ctx1 enable", d, 32'hFFFF_FFFE);
    rd(EN0, d); check("R3 ctx0 untouched", d, 0);

    // Priorities for table
    wr(22'h04, 3); wr(22'h08, 5); wr(22'h0C, 5); wr(22'h10, 0);
    wr(22'h14, 7); wr(22'h18, 2); wr(22'h1C, 7); wr(22'h20, 1);
    wr(22'h40, 4);

    // R4/R5: table of arbitration patterns
    for (int r = 0; r < NROWS; r++) begin
      logic [22:0] row;
      row = ROWS[r];
      drain();
      wr(EN0, {23'd0, row[14:7], 1'b0});
      wr(THR0, {29'd0, row[6:4]});
      @(negedge clk);
      src[8:1] = row[22:15];
      idle(3);
      check("R4 irq level", {31'd0, irq[0]}, {31'd0, row[3:0] != 0});
      rd(CLM0, d);
      check("R5 claim winner", d, {28'd0, row[3:0]});
      @(negedge clk);
      src[8:1] = 8'd0;
      if (row[3:0] != 0) wr(CLM0, {28'd0, row[3:0]});
    end
    drain();

    // R6: pending bit visible and cleared by claim
    @(negedge clk); src[1] = 1'b1;
    idle(3);
    rd(PEND0, d); check("R6 pending set", d & 32'h2, 32'h2);
    rd(CLM0, d);  check("R6 claim id", d, 1);
    rd(PEND0, d); check("R6 pending cleared", d & 32'h2, 0);

    // R7: held source invisible to the other context
    idle(3);
    rd(PEND0, d); check("R7 not re-pending while held", d & 32'h2, 0);
    rd(CLM1, d);  check("R7 ctx1 claim", d, 0);
    check("R7 ctx1 irq", {31'd0, irq[1]}, 0);

    // R8: completion while disabled is ignored
    wr(EN0, 32'hFFFF_FFFD);
    wr(CLM0, 1);
    idle(3);
    rd(PEND0, d); check("R8 disabled completion ignored", d & 32'h2, 0);

    // R9: enabled completion with level still high re-pends
    wr(EN0, 32'hFFFF_FFFF);
    wr(CLM0, 1);
    idle(3);
    rd(PEND0, d); check("R9 level re-pend", d & 32'h2, 32'h2);
    rd(CLM0, d);  check("R9 reclaim", d, 1);
    @(negedge clk); src[1] = 1'b0;
    wr(CLM0, 1);
    drain();

    // R10: edge source held high does not re-pend
    @(negedge clk); src[16] = 1'b1;
    idle(3);
    rd(PEND0, d); check("R10 edge pends", d & 32'h1_0000, 32'h1_0000);
    rd(CLM0, d);  check("R10 claim edge", d, 16);
    wr(CLM0, 16);
    idle(3);
    rd(PEND0, d); check("R10 steady high no re-pend", d & 32'h1_0000, 0);
    @(negedge clk); src[16] = 1'b0;
    idle(2);
    @(negedge clk); src[16] = 1'b1;
    idle(3);
    rd(PEND0, d); check("R10 new edge pends", d & 32'h1_0000, 32'h1_0000);
    rd(CLM0, d);  check("R10 second claim", d, 16);
    @(negedge clk); src[16] = 1'b0;
    wr(CLM0, 16);
    drain();

    // R11: same-cycle claim read and completion write
    @(negedge clk); src[2:1] = 2'b11;
    idle(3);
    rd(CLM0, d); check("R11 first claim", d, 2);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = CLM0;
    wr_en = 1'b1; wr_addr = CLM0; wr_data = 32'd2;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R11 read before completion", rd_data, 1);
    idle(3);
    rd(CLM0, d); check("R11 completion applied", d, 2);
    @(negedge clk); src[2:1] = 2'b00;
    wr(CLM0, 2); wr(CLM0, 1);

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule